// File: doc/BRIEF.md
# Three-Counter Event Monitor

This block counts hardware events for profiling. It has one control word and three 32-bit counters: two event counters, each of which follows one line of a 32-bit vector of single-cycle event pulses chosen by an 8-bit code, and one cycle counter. The cycle counter can also run at a rate divided by 64. A single global enable starts and stops all counting. No counter has an enable of its own. Software stops one event counter by giving it a code that never fires. A new code starts it again.

Each counter has a sticky overflow flag, which is set when the counter wraps from all ones to zero. Each flag also has an interrupt enable. One shared interrupt line combines the three sources. The flags sit in the control word next to the configuration. Software clears them by writing back the value it read: a 1 in a flag bit clears that flag, and the other fields take back the values they already hold. Software reads and writes all four registers through a plain port. Writes take effect at the next clock edge, and reads return data in the same cycle.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset the control word, all three counters and `irq` read as zero.
- R2: A write to address 1 (cycle counter), 2 (event counter 0) or 3 (event counter 1) loads the value, zero included. While counting is stopped, the value reads back unchanged.
- R3: Control bit 0 is the global enable. While it is 0, no counter changes except through a software write or a reset strobe.
- R4: Event counter 0 takes its code from control bits [27:20], and event counter 1 from bits [19:12]. A code from 0x00 to 0x1F adds one for each clock edge at which `evt_pulse[code]` is 1.
- R5: Code 0xFF adds one on every enabled cycle. Code 0x20 and every other code outside 0x00 to 0x1F never add anything.
- R6: Writing control bit 1 as 1 clears both event counters. Writing control bit 2 as 1 clears the cycle counter and its prescaler. Both bits always read back as 0.
- R7: With control bit 3 at 0, the cycle counter adds one on every enabled cycle. With bit 3 at 1, it adds one on every 64th enabled cycle, counted from the strobe that cleared it.
- R8: A wrap from 0xFFFFFFFF to 0 sets the flag at control bit 8 (event counter 0), bit 9 (event counter 1) or bit 10 (cycle counter). Loading 0xFFFFFFFF from software sets no flag.
- R9: Writing 1 to a flag bit clears that flag, and writing 0 leaves it as it is. If a clear and a new wrap of the same counter fall in the same cycle, the flag ends up set.
- R10: `irq` is 1 exactly when some flag is set and its enable is set. Bits 4, 5 and 6 are the enables for event counter 0, event counter 1 and the cycle counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 cycle counter, 2 event counter 0, 3 event counter 1 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, same cycle |
| evt_pulse | input | 32 | Single-cycle event pulses |
| irq | output | 1 | Shared overflow interrupt |

## Verification
The bound checker checks several rules on every cycle:
- A wrap is always followed by its flag.
- A flag stays set unless a write clears it.
- No counter moves while the global enable is low.
- The event-counter clear strobe empties both event counters.
- The undivided cycle counter steps by exactly one.
- `irq` is never raised without a flag.

Only the bench scenarios can show that:
- the right pulse line is counted for a given code;
- dead codes freeze a counter;
- the divided rate gives its first count on exactly the 64th cycle;
- a clear and a wrap in the same cycle leave the flag set;
- writing back the value that was read clears the interrupt.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int SEL_W     = 8;
  localparam int EVT_W     = 32;
  localparam int EVT_IDX_W = $clog2(EVT_W);
  localparam int DATA_W    = 32;
  localparam int NUM_CTR   = 3;

  // control word bit positions (software decodes these)
  localparam int CB_EN      = 0;
  localparam int CB_RST_EVT = 1;
  localparam int CB_RST_CYC = 2;
  localparam int CB_DIV     = 3;
  localparam int CB_IE_LO   = 4;
  localparam int CB_OVF_LO  = 8;
  localparam int CB_SEL1_LO = 12;
  localparam int CB_SEL0_LO = 20;

  localparam logic [SEL_W-1:0] CODE_CYCLES = 8'hFF;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_CYC  = 2'd1,
    RA_EVT0 = 2'd2,
    RA_EVT1 = 2'd3
  } reg_addr_e;

  // does the selected event fire this cycle
  function automatic logic event_fires(input logic [SEL_W-1:0] code,
                                       input logic [EVT_W-1:0] pulses);
    if (code == CODE_CYCLES) return 1'b1;
    if (code < SEL_W'(EVT_W)) return pulses[code[EVT_IDX_W-1:0]];
    return 1'b0;
  endfunction

  // sticky flag update: a new set wins over a clear in the same cycle
  function automatic logic [NUM_CTR-1:0] next_flags(input logic [NUM_CTR-1:0] cur,
                                                    input logic [NUM_CTR-1:0] clr,
                                                    input logic [NUM_CTR-1:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/pmu_ctrl_reg.sv
module pmu_ctrl_reg
  import pmu_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_ctrl,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [NUM_CTR-1:0]      wrap_evt,
  output logic                    count_en,
  output logic                    div_mode,
  output logic [NUM_CTR-1:0]      irq_en,
  output logic [NUM_CTR-1:0]      ovf_flags,
  output logic [SEL_W-1:0]        sel0,
  output logic [SEL_W-1:0]        sel1,
  output logic                    rst_evt_stb,
  output logic                    rst_cyc_stb,
  output logic [DATA_W-1:0]       ctrl_word
);
  logic [NUM_CTR-1:0] clr_req;
  logic               unused_wbits;

  assign rst_evt_stb  = wr_ctrl & wdata[CB_RST_EVT];
  assign rst_cyc_stb  = wr_ctrl & wdata[CB_RST_CYC];
  assign clr_req      = wr_ctrl ? wdata[CB_OVF_LO +: NUM_CTR] : '0;
  assign unused_wbits = ^{wdata[7], wdata[11], wdata[DATA_W-1:CB_SEL0_LO+SEL_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_en  <= 1'b0;
      div_mode  <= 1'b0;
      irq_en    <= '0;
      ovf_flags <= '0;
      sel0      <= '0;
      sel1      <= '0;
    end else begin
      if (wr_ctrl) begin
        count_en <= wdata[CB_EN];
        div_mode <= wdata[CB_DIV];
        irq_en   <= wdata[CB_IE_LO +: NUM_CTR];
        sel0     <= wdata[CB_SEL0_LO +: SEL_W];
        sel1     <= wdata[CB_SEL1_LO +: SEL_W];
      end
      ovf_flags <= next_flags(ovf_flags, clr_req, wrap_evt);
    end
  end

  always_comb begin
    ctrl_word                          = '0;
    ctrl_word[CB_EN]                   = count_en;
    ctrl_word[CB_DIV]                  = div_mode;
    ctrl_word[CB_IE_LO +: NUM_CTR]     = irq_en;
    ctrl_word[CB_OVF_LO +: NUM_CTR]    = ovf_flags;
    ctrl_word[CB_SEL1_LO +: SEL_W]     = sel1;
    ctrl_word[CB_SEL0_LO +: SEL_W]     = sel0;
  end
endmodule

// File: rtl/pmu_evt_counter.sv
module pmu_evt_counter
  import pmu_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              count_en,
  input  logic [SEL_W-1:0]  sel,
  input  logic [EVT_W-1:0]  pulses,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_val,
  input  logic              clr,
  output logic [CNT_W-1:0]  count,
  output logic              wrap
);
  logic hit;

  assign hit  = count_en && event_fires(sel, pulses);
  assign wrap = hit && !load && !clr && (count == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (clr)  count <= '0;
    else if (load) count <= load_val;
    else if (hit)  count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/pmu_cyc_counter.sv
module pmu_cyc_counter #(
  parameter int CNT_W         = 32,
  parameter int PRESCALE_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              count_en,
  input  logic              div_mode,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_val,
  input  logic              clr,
  output logic [CNT_W-1:0]  count,
  output logic              wrap
);
  logic [PRESCALE_LOG2-1:0] pre;
  logic                     tick;

  assign tick = count_en && (!div_mode || (pre == '1));
  assign wrap = tick && !load && !clr && (count == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     pre <= '0;
    else if (clr)                   pre <= '0;
    else if (count_en && div_mode)  pre <= pre + PRESCALE_LOG2'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (clr)  count <= '0;
    else if (load) count <= load_val;
    else if (tick) count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int CNT_W         = 32,
  parameter int PRESCALE_LOG2 = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [1:0]          reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [EVT_W-1:0]    evt_pulse,
  output logic                irq
);
  localparam int NUM_EVT = 2;

  logic                         count_en;
  logic                         div_mode;
  logic [NUM_CTR-1:0]           irq_en;
  logic [NUM_CTR-1:0]           ovf_flags;
  logic [NUM_CTR-1:0]           wrap_evt;
  logic [SEL_W-1:0]             sel0;
  logic [SEL_W-1:0]             sel1;
  logic                         rst_evt_stb;
  logic                         rst_cyc_stb;
  logic [DATA_W-1:0]            ctrl_word;
  logic [NUM_EVT-1:0][SEL_W-1:0] sel_arr;
  logic [NUM_EVT-1:0][CNT_W-1:0] evt_cnt;
  logic [NUM_EVT-1:0]           evt_wrap;
  logic [CNT_W-1:0]             cyc_cnt;
  logic                         cyc_wrap;
  logic [CNT_W-1:0]             evt0_cnt;
  logic [CNT_W-1:0]             evt1_cnt;
  logic                         wr_ctrl;
  logic                         wr_cyc;

  assign wr_ctrl  = reg_wr && (reg_addr == RA_CTRL);
  assign wr_cyc   = reg_wr && (reg_addr == RA_CYC);
  assign sel_arr  = {sel1, sel0};
  assign wrap_evt = {cyc_wrap, evt_wrap[1], evt_wrap[0]};
  assign evt0_cnt = evt_cnt[0];
  assign evt1_cnt = evt_cnt[1];

  pmu_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctrl    (wr_ctrl),
    .wdata      (reg_wdata),
    .wrap_evt   (wrap_evt),
    .count_en   (count_en),
    .div_mode   (div_mode),
    .irq_en     (irq_en),
    .ovf_flags  (ovf_flags),
    .sel0       (sel0),
    .sel1       (sel1),
    .rst_evt_stb(rst_evt_stb),
    .rst_cyc_stb(rst_cyc_stb),
    .ctrl_word  (ctrl_word)
  );

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    logic load_g;
    assign load_g = reg_wr && (reg_addr == (2'(RA_EVT0) + 2'(g)));
    pmu_evt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .count_en(count_en),
      .sel     (sel_arr[g]),
      .pulses  (evt_pulse),
      .load    (load_g),
      .load_val(reg_wdata[CNT_W-1:0]),
      .clr     (rst_evt_stb),
      .count   (evt_cnt[g]),
      .wrap    (evt_wrap[g])
    );
  end

  pmu_cyc_counter #(.CNT_W(CNT_W), .PRESCALE_LOG2(PRESCALE_LOG2)) u_cyc (
    .clk     (clk),
    .rst_n   (rst_n),
    .count_en(count_en),
    .div_mode(div_mode),
    .load    (wr_cyc),
    .load_val(reg_wdata[CNT_W-1:0]),
    .clr     (rst_cyc_stb),
    .count   (cyc_cnt),
    .wrap    (cyc_wrap)
  );

  assign irq = |(ovf_flags & irq_en);

  always_comb begin
    unique case (reg_addr)
      RA_CTRL: reg_rdata = ctrl_word;
      RA_CYC:  reg_rdata = DATA_W'(cyc_cnt);
      RA_EVT0: reg_rdata = DATA_W'(evt0_cnt);
      default: reg_rdata = DATA_W'(evt1_cnt);
    endcase
  end
endmodule

// File: rtl/pmu_mon_checker.sv
module pmu_mon_checker #(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              irq,
  input logic              count_en,
  input logic              div_mode,
  input logic [2:0]        ovf_flags,
  input logic [2:0]        wrap_evt,
  input logic [CNT_W-1:0]  evt0_cnt,
  input logic [CNT_W-1:0]  evt1_cnt,
  input logic [CNT_W-1:0]  cyc_cnt
);
  logic ctrl_wr;
  assign ctrl_wr = reg_wr && (reg_addr == 2'd0);

  // R10
  irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf_flags != 3'b000));

  // R8
  evt0_wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt[0] |=> ovf_flags[0]);

  // R8
  cyc_wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt[2] |=> ovf_flags[2]);

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flags[1] && !(ctrl_wr && reg_wdata[9])) |=> ovf_flags[1]);

  // R3
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !reg_wr) |=> ($stable(evt0_cnt) && $stable(evt1_cnt) && $stable(cyc_cnt)));

  // R6
  evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && reg_wdata[1]) |=> ((evt0_cnt == '0) && (evt1_cnt == '0)));

  // R7
  cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !div_mode && !reg_wr) |=> (cyc_cnt == $past(cyc_cnt) + CNT_W'(1)));
endmodule

bind perf_mon_unit pmu_mon_checker #(.CNT_W(CNT_W)) u_mon_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .irq      (irq),
  .count_en (count_en),
  .div_mode (div_mode),
  .ovf_flags(ovf_flags),
  .wrap_evt (wrap_evt),
  .evt0_cnt (evt0_cnt),
  .evt1_cnt (evt1_cnt),
  .cyc_cnt  (cyc_cnt)
);

// File: tb/perf_mon_unit_test.sv
`timescale 1ns/1ps
module perf_mon_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] evt_pulse = '0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  perf_mon_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse), .irq(irq)
  );

  // row: {ctr[18], en[17], sel[16:9], line[8:4], pulses[3:0]}
  localparam logic [18:0] VEC [7] = '{
    {1'b0, 1'b1, 8'h03, 5'd3,  4'd5},
    {1'b0, 1'b1, 8'h03, 5'd4,  4'd5},
    {1'b1, 1'b1, 8'h1F, 5'd31, 4'd4},
    {1'b1, 1'b1, 8'h20, 5'd0,  4'd6},
    {1'b0, 1'b0, 8'h07, 5'd7,  4'd3},
    {1'b1, 1'b1, 8'h40, 5'd0,  4'd3},
    {1'b1, 1'b1, 8'h00, 5'd0,  4'd7}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input int line);
    @(negedge clk);
    evt_pulse[line] = 1'b1;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] ctl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); check("R1 ctrl", v, 32'h0);
    rd(2'd1, v); check("R1 cyc", v, 32'h0);
    rd(2'd2, v); check("R1 evt0", v, 32'h0);
    rd(2'd3, v); check("R1 evt1", v, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);

    // R2 direct loads, counting stopped
    wr(2'd2, 32'h12345678); rd(2'd2, v); check("R2 evt0 load", v, 32'h12345678);
    wr(2'd2, 32'h0);        rd(2'd2, v); check("R2 evt0 zero", v, 32'h0);
    wr(2'd1, 32'hABCDEF01); repeat (4) @(negedge clk); rd(2'd1, v); check("R2 cyc hold", v, 32'hABCDEF01);
    wr(2'd3, 32'h00C0FFEE); rd(2'd3, v); check("R2 evt1 load", v, 32'h00C0FFEE);

    // table walk: R3 / R4 / R5
    for (int i = 0; i < 7; i++) begin
      logic [18:0] r;
      logic [31:0] expv;
      string tag;
      r = VEC[i];
      if (r[18] == 1'b0) ctl = (32'(r[16:9]) << 20) | (32'h20 << 12);
      else               ctl = (32'h20 << 20) | (32'(r[16:9]) << 12);
      wr(2'd0, ctl | 32'h2 | 32'(r[17]));
      for (int k = 0; k < int'(r[3:0]); k++) pulse(int'(r[8:4]));
      wr(2'd0, ctl);
      expv = (r[17] && (r[16:9] < 8'd32) && (r[13:9] == r[8:4])) ? 32'(r[3:0]) : 32'h0;
      if (!r[17])            tag = "R3 disabled";
      else if (r[16:9] >= 8'd32) tag = "R5 dead code";
      else                   tag = "R4 event select";
      rd(r[18] ? 2'd3 : 2'd2, v);
      check(tag, v, expv);
    end

    // R5 code 0xFF counts cycles
    wr(2'd0, 32'h1 | 32'h2 | (32'hFF << 20) | (32'h20 << 12));
    repeat (5) @(negedge clk);
    rd(2'd2, v); check("R5 cycle code", v, 32'd5);

    // R6 / R7 cycle counter full rate
    wr(2'd0, 32'h1 | 32'h4 | (32'h20 << 20) | (32'h20 << 12));
    rd(2'd1, v); check("R6 cyc clear", v, 32'h0);
    rd(2'd0, v); check("R6 strobes read 0", v & 32'h6, 32'h0);
    repeat (10) @(negedge clk);
    rd(2'd1, v); check("R7 full rate", v, 32'd10);

    // R7 divided rate
    wr(2'd0, 32'h1 | 32'h4 | 32'h8 | (32'h20 << 20) | (32'h20 << 12));
    repeat (63) @(negedge clk);
    rd(2'd1, v); check("R7 div before 64", v, 32'd0);
    @(negedge clk);
    rd(2'd1, v); check("R7 div at 64", v, 32'd1);

    // R8 overflow of event counter 0
    wr(2'd0, (32'h20 << 20) | (32'h20 << 12));
    wr(2'd2, 32'hFFFFFFFF);
    rd(2'd0, v); check("R8 load sets no flag", v & 32'h100, 32'h0);
    wr(2'd2, 32'hFFFFFFFE);
    ctl = 32'h1 | 32'h10 | (32'h03 << 20) | (32'h20 << 12);
    wr(2'd0, ctl);
    pulse(3);
    rd(2'd2, v); check("R8 at max", v, 32'hFFFFFFFF);
    rd(2'd0, v); check("R8 no flag yet", v & 32'h100, 32'h0);
    pulse(3);
    rd(2'd2, v); check("R8 wrapped", v, 32'h0);
    rd(2'd0, v); check("R8 flag set", v & 32'h100, 32'h100);
    check("R10 irq up", {31'h0, irq}, 32'h1);

    // R10 enable gating, R9 writing 0 keeps flag
    wr(2'd0, ctl & ~32'h10);
    check("R10 irq masked", {31'h0, irq}, 32'h0);
    rd(2'd0, v); check("R9 zero keeps flag", v & 32'h100, 32'h100);
    wr(2'd0, ctl);
    check("R10 irq restored", {31'h0, irq}, 32'h1);
    rd(2'd0, v);
    wr(2'd0, v);
    rd(2'd0, v); check("R9 write-back clears", v & 32'h100, 32'h0);
    check("R9 irq cleared", {31'h0, irq}, 32'h0);

    // R9 clear and wrap in same cycle: set wins
    wr(2'd0, (32'h20 << 20) | (32'h20 << 12));
    wr(2'd3, 32'hFFFFFFFF);
    ctl = 32'h1 | 32'h20 | (32'h20 << 20) | (32'h05 << 12);
    wr(2'd0, ctl);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = ctl | 32'h200; evt_pulse[5] = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; evt_pulse = '0;
    rd(2'd3, v); check("R9 counter wrapped", v, 32'h0);
    rd(2'd0, v); check("R9 set wins", v & 32'h200, 32'h200);
    check("R10 irq ctr1", {31'h0, irq}, 32'h1);
    wr(2'd0, ctl | 32'h200);
    rd(2'd0, v); check("R9 plain clear", v & 32'h200, 32'h0);

    // R8 cycle counter wrap
    wr(2'd0, (32'h20 << 20) | (32'h20 << 12));
    wr(2'd1, 32'hFFFFFFFF);
    wr(2'd0, 32'h1 | 32'h40 | (32'h20 << 20) | (32'h20 << 12));
    rd(2'd1, v); check("R8 cyc at max", v, 32'hFFFFFFFF);
    @(negedge clk);
    rd(2'd1, v); check("R8 cyc wrapped", v, 32'h0);
    rd(2'd0, v); check("R8 cyc flag", v & 32'h400, 32'h400);
    check("R10 irq cyc", {31'h0, irq}, 32'h1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule